// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the digital side of a converter's three-wire serial port, operating with an externally supplied serial clock and one conversion per readout. A chip-select input (`sel_n_i`, low = selected), a serial clock input (`sclk_i`) and a serial data output modelled as a data bit (`sdo_o`) plus an output enable (`sdo_oe_o`) form the host interface. Both host inputs are brought into the system clock domain through synchronisers with edge detectors, so every host action takes effect a fixed small number of system cycles after it happens.

Internally a three-state machine runs: `ST_CONVERT` (a conversion is counting down), `ST_SLEEP` (the result is held and waits for the host), and `ST_SHIFT` (the frame is being clocked out). Transitions: reset enters `ST_CONVERT`; `ST_CONVERT` goes to `ST_SLEEP` when the conversion counter expires, capturing the parallel result word; `ST_SLEEP` goes to `ST_SHIFT` on the first serial clock rising edge seen while selected in external clock mode; `ST_SHIFT` returns to `ST_CONVERT` either on the 32nd serial clock falling edge (frame complete) or on a deselect edge (abort). The clock mode is latched at every select edge. While selected outside a readout, the data pin shows a status bit: high while converting, low once a result waits.

The 32-bit frame goes out MSB first: a leading status bit of 0, then the 31 result bits from bit 30 down to bit 0.

Top module: `adc_serial_port`

## Requirements
- R1: On each falling edge of `sel_n_i` the clock mode is latched: external mode if `sclk_i` is low at that edge, otherwise not; outside external mode, serial clock edges never start a readout and the held result is not consumed, until a later select edge made with `sclk_i` low.
- R2: `sdo_oe_o` is 0 whenever `sel_n_i` has been high for at least 3 system cycles, and 1 when it has been low for at least 3 cycles.
- R3: While selected and not in `ST_SHIFT`, `sdo_o` is 1 during `ST_CONVERT` and 0 during `ST_SLEEP`.
- R4: A conversion lasts exactly `CONV_CYCLES` system cycles, after which the block enters `ST_SLEEP` regardless of `sel_n_i` and captures `result_i`; later changes of `result_i` do not alter the held frame.
- R5: In `ST_SLEEP`, the first `sclk_i` rising edge while selected in external mode enters `ST_SHIFT`; the value on `sdo_o` at that first rising edge is the status bit 0.
- R6: `sdo_o` advances on `sclk_i` falling edges; at the k-th rising edge (k = 2..32) it shows `result_i[32-k]` of the captured word.
- R7: The 32nd `sclk_i` falling edge starts a new conversion: `sdo_o` reads 1 three system cycles after that edge and reads 0 once the conversion ends with the select still low.
- R8: A rising edge of `sel_n_i` in `ST_SHIFT` (after the first rising and before the 32nd falling `sclk_i` edge) aborts the frame and starts a new conversion at once.
- R9: After reset the block is in `ST_CONVERT` with `sdo_oe_o` low until the select is observed low.
- R10: `sclk_i` edges during `ST_CONVERT` have no effect: `sdo_o` stays 1 and the conversion ends on schedule.
- R11: Toggling `sel_n_i` during `ST_SLEEP` does not disturb the held result; a later full readout returns the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Host chip select, low selects the port |
| sclk_i | input | 1 | Host serial clock |
| result_i | input | FRAME_BITS-1 | Parallel conversion result, captured when a conversion ends |
| sdo_o | output | 1 | Serial data / status bit |
| sdo_oe_o | output | 1 | Output enable for the serial data pin |

## Verification
The hardest situations to reach are the aborts at the very edges of the readout window: a deselect just after the first rising edge and one after the 32nd rising edge but before the 32nd falling edge, where a frame-end and an abort would otherwise be confused. The bench walks the abort point across several rising-edge counts, leaving the serial clock high when it deselects, then proves a fresh conversion began by watching the status bit and reading a new full frame. A select edge taken with the serial clock high is used to show the non-external mode leaves the held frame untouched.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
    typedef enum logic [1:0] {
        ST_CONVERT = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_SHIFT   = 2'd2
    } port_state_e;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES+1){INIT}};
        else        chain_q <= {chain_q[STAGES-1:0], d_i};
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [W-1:0] LOAD = W'(CYCLES - 1);

    logic [W-1:0] cnt_q;
    logic         act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LOAD;
            act_q <= 1'b1;
        end else if (start_i) begin
            cnt_q <= LOAD;
            act_q <= 1'b1;
        end else if (act_q) begin
            if (cnt_q == '0) act_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = act_q;
    assign done_o = act_q && (cnt_q == '0);

    // R4: a fresh start is never finished in the following cycle
    assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o && (CYCLES < 2 || !done_o));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] din_i,
    output logic         msb_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sr_q <= '0;
        else if (load_i)  sr_q <= din_i;
        else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign msb_o = sr_q[W-1];
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int FRAME_BITS  = 32,
    parameter int CONV_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_n_i,
    input  logic                  sclk_i,
    input  logic [FRAME_BITS-2:0] result_i,
    output logic                  sdo_o,
    output logic                  sdo_oe_o
);
    localparam int RES_W = FRAME_BITS - 1;
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_BITS - 1);

    port_state_e state_q, state_d;

    logic sel_lvl, sel_rise, sel_fall;
    logic sck_lvl, sck_rise, sck_fall;
    logic ext_mode_q;
    logic [CNT_W-1:0] fall_cnt_q;
    logic conv_start, conv_busy, conv_done;
    logic sr_load, sr_shift, sr_msb;

    sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sel_n_i),
        .level_o(sel_lvl), .rise_o(sel_rise), .fall_o(sel_fall)
    );

    sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sclk_i),
        .level_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall)
    );

    conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(conv_start),
        .busy_o(conv_busy), .done_o(conv_done)
    );

    frame_shifter #(.W(FRAME_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(sr_load), .shift_i(sr_shift),
        .din_i({1'b0, result_i[RES_W-1:0]}), .msb_o(sr_msb)
    );

    // clock mode latched at every select edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ext_mode_q <= 1'b0;
        else if (sel_fall) ext_mode_q <= ~sck_lvl;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONVERT;
        else        state_q <= state_d;
    end

    // falling-edge counter for the frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     fall_cnt_q <= '0;
        else if (state_q != ST_SHIFT)                   fall_cnt_q <= '0;
        else if (sck_fall && !sel_rise)                 fall_cnt_q <= fall_cnt_q + 1'b1;
    end

    // next state and control strobes
    always_comb begin
        state_d    = state_q;
        conv_start = 1'b0;
        sr_load    = 1'b0;
        sr_shift   = 1'b0;
        unique case (state_q)
            ST_CONVERT: begin
                if (conv_done) begin
                    state_d = ST_SLEEP;
                    sr_load = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (sck_rise && !sel_lvl && ext_mode_q) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sel_rise) begin
                    state_d    = ST_CONVERT;
                    conv_start = 1'b1;
                end else if (sck_fall) begin
                    if (fall_cnt_q == LAST_FALL) begin
                        state_d    = ST_CONVERT;
                        conv_start = 1'b1;
                    end else begin
                        sr_shift = 1'b1;
                    end
                end
            end
            default: state_d = ST_CONVERT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_CONVERT:         sdo_o = 1'b1;
            ST_SLEEP, ST_SHIFT: sdo_o = sr_msb;
            default:            sdo_o = 1'b1;
        endcase
        sdo_oe_o = ~sel_lvl;
    end

    assert_done_sleeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && conv_done) |=> state_q == ST_SLEEP);

    assert_first_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && sck_rise && !sel_lvl && ext_mode_q) |=> state_q == ST_SHIFT);

    assert_no_readout_internal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !ext_mode_q) |=> state_q != ST_SHIFT);

    assert_abort_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sel_rise) |=> (state_q == ST_CONVERT && conv_busy));

    assert_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sck_fall && fall_cnt_q == LAST_FALL) |=> (state_q == ST_CONVERT && conv_busy));

    assert_sleep_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && $past(state_q) == ST_SLEEP) |-> $stable(sdo_o));

    assert_convert_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && !$past(conv_done)) |-> conv_busy);
endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
    localparam int FB   = 32;
    localparam int C    = 200;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sclk = 1'b0;
    logic [FB-2:0] res = '0;
    logic sdo, sdo_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_serial_port #(.FRAME_BITS(FB), .CONV_CYCLES(C), .SYNC_STAGES(2)) i_adc_serial_port (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk),
        .result_i(res), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [FB-2:0] pat(input int p);
        if (p < FB - 1) return (31'(1) << p);
        else if (p == FB - 1) return '1;
        else if (p == FB) return 31'h2AAA_AAAA;
        else if (p == FB + 1) return 31'h5555_5555;
        else return 31'h7000_0001;
    endfunction

    // reads n bits, sampling at each rising edge; sclk is left high afterwards
    task automatic read_bits(input int n, output logic [31:0] f);
        f = '0;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            wait_clk(HALF);
            f[31-i] = sdo;
            if (i < n - 1) begin
                sclk = 1'b0;
                wait_clk(HALF);
            end
        end
    endtask

    // 32nd falling edge then timed conversion checks (R7, R4)
    task automatic end_frame(input logic [FB-2:0] next_res);
        sclk = 1'b0;
        res  = next_res;
        wait_clk(3);
        check(sdo === 1'b1, "R7 conversion starts at frame end", {31'd0, sdo}, 32'd1);
        wait_clk(C - 1);
        check(sdo === 1'b1, "R4 still converting one cycle before end", {31'd0, sdo}, 32'd1);
        wait_clk(1);
        check(sdo === 1'b0, "R4 R7 sleep after CONV_CYCLES", {31'd0, sdo}, 32'd0);
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                total++;
                bad++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] f;
        logic [FB-2:0] held;
        res = pat(0);
        wait_clk(4);
        check(sdo_oe === 1'b0, "R9 output disabled in reset", {31'd0, sdo_oe}, 32'd0);
        rst_n = 1'b1;
        wait_clk(4);
        check(sdo_oe === 1'b0, "R9 R2 disabled while deselected", {31'd0, sdo_oe}, 32'd0);
        sel_n = 1'b0;
        wait_clk(4);
        check(sdo_oe === 1'b1, "R2 enabled when selected", {31'd0, sdo_oe}, 32'd1);
        check(sdo === 1'b1, "R9 R3 converting after reset", {31'd0, sdo}, 32'd1);
        wait_clk(C + 10);
        check(sdo === 1'b0, "R3 status low when asleep", {31'd0, sdo}, 32'd0);

        // sweep of result patterns, R5 R6
        for (int p = 0; p < FB + 2; p++) begin
            read_bits(FB, f);
            check(f === {1'b0, pat(p)}, "R5 R6 frame content", f, {1'b0, pat(p)});
            end_frame(pat(p + 1));
        end
        held = pat(FB + 2);

        // R4 hold + R11 select toggles in sleep
        sel_n = 1'b1;
        wait_clk(8);
        check(sdo_oe === 1'b0, "R2 disabled after deselect", {31'd0, sdo_oe}, 32'd0);
        res = 31'h0F0F_0F0F;
        sel_n = 1'b0;
        wait_clk(8);
        check(sdo === 1'b0, "R11 still asleep after toggle", {31'd0, sdo}, 32'd0);

        // R1: select with sclk high, clock edges ignored
        sel_n = 1'b1;
        wait_clk(8);
        sclk = 1'b1;
        wait_clk(8);
        sel_n = 1'b0;
        wait_clk(8);
        for (int k = 0; k < 4; k++) begin
            sclk = 1'b0;
            wait_clk(HALF);
            check(sdo === 1'b0, "R1 no shifting outside external mode", {31'd0, sdo}, 32'd0);
            sclk = 1'b1;
            wait_clk(HALF);
        end
        sclk = 1'b0;
        wait_clk(8);
        sel_n = 1'b1;
        wait_clk(8);
        sel_n = 1'b0;
        wait_clk(8);
        read_bits(FB, f);
        check(f === {1'b0, held}, "R1 R11 R4 held frame intact", f, {1'b0, held});
        end_frame(31'h1357_9BDF);
        held = 31'h1357_9BDF;

        // abort sweep, R8 R10
        for (int a = 0; a < 5; a++) begin
            int k;
            logic [FB-2:0] nv;
            k = (a == 0) ? 1 : (a == 1) ? 2 : (a == 2) ? 16 : (a == 3) ? 31 : 32;
            nv = 31'(32'h0ABC_0000 + 32'(k) * 32'h0001_0203);
            read_bits(k, f);
            check(f[31] === 1'b0, "R5 status bit first", {31'd0, f[31]}, 32'd0);
            sel_n = 1'b1;
            res = nv;
            wait_clk(8);
            check(sdo_oe === 1'b0, "R2 R8 disabled after abort", {31'd0, sdo_oe}, 32'd0);
            sclk = 1'b0;
            wait_clk(8);
            sel_n = 1'b0;
            wait_clk(8);
            check(sdo === 1'b1, "R8 abort restarts conversion", {31'd0, sdo}, 32'd1);
            for (int q = 0; q < 3; q++) begin
                sclk = 1'b1;
                wait_clk(HALF);
                sclk = 1'b0;
                wait_clk(HALF);
            end
            check(sdo === 1'b1, "R10 clock ignored while converting", {31'd0, sdo}, 32'd1);
            wait_clk(C);
            check(sdo === 1'b0, "R8 R10 conversion finished", {31'd0, sdo}, 32'd0);
            read_bits(FB, f);
            check(f === {1'b0, nv}, "R8 frame after abort", f, {1'b0, nv});
            sclk = 1'b0;
            wait_clk(C + 10);
        end
        finish_run();
    end
endmodule